// File: doc/BRIEF.md
# Systolic FIR Filter Array

This block filters a stream of signed samples with a finite impulse response of `TAPS` coefficients, producing y(i) = Σ H(n)·x(i−n) for n = 0 … TAPS−1. It is built as a linear chain of identical processing elements. Each element owns one coefficient and performs one multiply-accumulate every clock. Partial sums hop one element per clock towards the output end. Samples travel the same way at half that speed, through two registers per element, so each element meets the sample that is 2p clocks older than the newest one at its input.

Coefficients are loaded serially through a shift chain while the stream is idle. After that, one sample may be offered every clock. A slot in which no sample is accepted enters the array as a zero sample, and its output slot is flagged not valid. A flag runs alongside the partial sums, so each filtered result leaves the last element with a fixed latency and a matching valid strobe. The accumulators are wide enough that no input combination can overflow them.

Top module: `systolic_fir`

## Requirements
- R1: While reset is asserted, and after its release until the first accepted sample has crossed the array, `yValid` is 0 and `yOut` is 0.
- R2: Each clock in which `coefLoad` is 1 shifts `coefIn` into the coefficient chain at element 0, and every stored coefficient moves one element further. After TAPS load clocks, the value loaded first is H(TAPS−1), which weights the oldest sample x(i−TAPS+1), and the value loaded last is H(0), which weights the newest sample.
- R3: For every accepted sample i, the output is the full-precision sum Σ H(n)·x(i−n), with all samples and coefficients read as two's-complement numbers. Sample slots before the first one accepted after reset count as zero.
- R4: A sample accepted at a rising edge has its result on `yOut`, with `yValid` = 1, right after the rising edge TAPS−1 clocks later. With continuous input, one result comes out per clock.
- R5: A clock with `sampleValid` = 0 enters the array as a zero sample. Its output slot has `yValid` = 0, and later results treat it as x = 0.
- R6: `coefLoad` takes priority over `sampleValid`. A sample offered in a load clock is not accepted: it counts as a zero sample and its output slot has `yValid` = 0.
- R7: The accumulator is XW+HW+⌈log2 TAPS⌉ bits wide. The extreme case, all samples and coefficients at the most negative value, gives TAPS·2^(XW+HW−2) exactly.
- R8: While `coefLoad` is 0, the stored coefficients do not change, whatever value `coefIn` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| coefLoad | input | 1 | Shift `coefIn` into the coefficient chain this clock |
| coefIn | input | HW | Signed coefficient to load |
| sampleValid | input | 1 | `sampleIn` holds a sample this clock |
| sampleIn | input | XW | Signed input sample |
| yValid | output | 1 | `yOut` holds a filtered result |
| yOut | output | XW+HW+⌈log2 TAPS⌉ | Signed filtered result |

## Verification
A sample accepted at rising edge e is due on `yOut` and `yValid` after edge e+TAPS−1, because it passes TAPS partial-sum registers. The valid flag for that sample moves through TAPS registers in step with it. The bench drives every input on a falling edge and records what the next rising edge accepts. On the falling edge after that it checks the slot accepted TAPS−1 edges earlier against a sum computed from its own sample history. The checker holds separate TAPS-deep records of accepted samples and load clocks, and it counts idle clocks up to 2·TAPS−1, the span after which every partial sum must be made only of zero samples.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic shiftCoef;   // advance the coefficient chain by one element
    logic takeSample;  // present sample enters the array (else a zero)
  } firStrobe_t;

endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
#(
  parameter int TAPS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       coefLoad,
  input  logic       sampleValid,
  output firStrobe_t strobe,
  output logic       outValid
);

  // One flag per element, moving with the partial sums
  logic [TAPS-1:0] validPipe;

  always_comb begin
    strobe.shiftCoef  = coefLoad;
    strobe.takeSample = sampleValid && !coefLoad;  // loading wins
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe[0] <= strobe.takeSample;
      for (int i = 1; i < TAPS; i++) begin
        validPipe[i] <= validPipe[i-1];
      end
    end
  end

  assign outValid = validPipe[TAPS-1];

endmodule

// File: rtl/fir_pe.sv
module fir_pe #(
  parameter int XW = 8,
  parameter int HW = 8,
  parameter int AW = 19
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [HW-1:0] coef,
  input  logic signed [XW-1:0] xTap,
  input  logic signed [AW-1:0] sumIn,
  output logic signed [AW-1:0] sumOut
);

  localparam int PW = XW + HW;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prodExt;

  assign prod    = PW'(xTap) * PW'(coef);
  assign prodExt = AW'(prod);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumOut <= '0;
    end else begin
      sumOut <= sumIn + prodExt;
    end
  end

endmodule

// File: rtl/fir_datapath.sv
module fir_datapath
  import fir_pkg::*;
#(
  parameter int TAPS = 5,
  parameter int XW   = 8,
  parameter int HW   = 8,
  parameter int AW   = 19
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  firStrobe_t           strobe,
  input  logic signed [HW-1:0] coefIn,
  input  logic signed [XW-1:0] sampleIn,
  output logic signed [AW-1:0] yOut
);

  logic signed [HW-1:0] coefVec [TAPS];
  logic signed [XW-1:0] xTap    [TAPS];
  logic signed [AW-1:0] sumQ    [TAPS];
  logic signed [XW-1:0] xEntry;

  // A slot with no accepted sample enters as zero
  assign xEntry  = strobe.takeSample ? sampleIn : '0;
  assign xTap[0] = xEntry;

  // Coefficient shift chain: element 0 takes the new value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) coefVec[i] <= '0;
    end else if (strobe.shiftCoef) begin
      coefVec[0] <= coefIn;
      for (int i = 1; i < TAPS; i++) coefVec[i] <= coefVec[i-1];
    end
  end

  // Sample path: two registers between neighbouring elements
  generate
    if (TAPS > 1) begin : gDelay
      logic signed [XW-1:0] xPipe [2*TAPS-2];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < 2*TAPS-2; i++) xPipe[i] <= '0;
        end else begin
          xPipe[0] <= xEntry;
          for (int i = 1; i < 2*TAPS-2; i++) xPipe[i] <= xPipe[i-1];
        end
      end
      for (genvar p = 1; p < TAPS; p++) begin : gTap
        assign xTap[p] = xPipe[2*p-1];
      end
    end
  endgenerate

  // Element chain: partial sums advance one element per clock
  generate
    for (genvar p = 0; p < TAPS; p++) begin : gPe
      logic signed [AW-1:0] sumIn;
      if (p == 0) begin : gHead
        assign sumIn = '0;
      end else begin : gBody
        assign sumIn = sumQ[p-1];
      end
      fir_pe #(.XW(XW), .HW(HW), .AW(AW)) u_pe (
        .clk   (clk),
        .rstN  (rstN),
        .coef  (coefVec[p]),
        .xTap  (xTap[p]),
        .sumIn (sumIn),
        .sumOut(sumQ[p])
      );
    end
  endgenerate

  assign yOut = sumQ[TAPS-1];

endmodule

// File: rtl/systolic_fir.sv
module systolic_fir
  import fir_pkg::*;
#(
  parameter  int TAPS = 5,
  parameter  int XW   = 8,
  parameter  int HW   = 8,
  localparam int AW   = XW + HW + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 coefLoad,
  input  logic signed [HW-1:0] coefIn,
  input  logic                 sampleValid,
  input  logic signed [XW-1:0] sampleIn,
  output logic                 yValid,
  output logic signed [AW-1:0] yOut
);

  firStrobe_t strobe;

  fir_ctrl #(.TAPS(TAPS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .coefLoad   (coefLoad),
    .sampleValid(sampleValid),
    .strobe     (strobe),
    .outValid   (yValid)
  );

  fir_datapath #(.TAPS(TAPS), .XW(XW), .HW(HW), .AW(AW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .coefIn  (coefIn),
    .sampleIn(sampleIn),
    .yOut    (yOut)
  );

endmodule

// File: rtl/fir_chk.sv
module fir_chk #(
  parameter  int TAPS = 5,
  parameter  int XW   = 8,
  parameter  int HW   = 8,
  localparam int AW   = XW + HW + $clog2(TAPS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 coefLoad,
  input logic                 sampleValid,
  input logic                 yValid,
  input logic signed [AW-1:0] yOut
);

  localparam longint BOUND = longint'(TAPS) <<< (XW + HW - 2);

  logic [TAPS-1:0] offerPipe;  // sampleValid history
  logic [TAPS-1:0] loadPipe;   // coefLoad history
  int idleCnt;                 // consecutive clocks with nothing accepted

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offerPipe <= '0;
      loadPipe  <= '0;
      idleCnt   <= 0;
    end else begin
      offerPipe[0] <= sampleValid;
      loadPipe[0]  <= coefLoad;
      for (int i = 1; i < TAPS; i++) begin
        offerPipe[i] <= offerPipe[i-1];
        loadPipe[i]  <= loadPipe[i-1];
      end
      if (sampleValid && !coefLoad) idleCnt <= 0;
      else if (idleCnt < 2*TAPS)   idleCnt <= idleCnt + 1;
    end
  end

  AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    yValid |-> offerPipe[TAPS-1]);  // R4

  AST_VALID_ON_TIME: assert property (@(posedge clk) disable iff (!rstN)
    (offerPipe[TAPS-1] && !loadPipe[TAPS-1]) |-> yValid);  // R4

  AST_LOAD_DROPS_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    loadPipe[TAPS-1] |-> !yValid);  // R6

  AST_IDLE_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt >= 2*TAPS-1) |-> (yOut == '0));  // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    yValid |-> (longint'(yOut) <= BOUND && longint'(yOut) >= -BOUND));  // R7

endmodule

bind systolic_fir fir_chk #(.TAPS(TAPS), .XW(XW), .HW(HW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .coefLoad   (coefLoad),
  .sampleValid(sampleValid),
  .yValid     (yValid),
  .yOut       (yOut)
);

// File: tb/sim_systolic_fir.sv
module sim_systolic_fir;

  localparam int TAPS = 5;
  localparam int XW   = 8;
  localparam int HW   = 8;
  localparam int AW   = XW + HW + $clog2(TAPS);

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 coefLoad = 1'b0;
  logic signed [HW-1:0] coefIn = '0;
  logic                 sampleValid = 1'b0;
  logic signed [XW-1:0] sampleIn = '0;
  logic                 yValid;
  logic signed [AW-1:0] yOut;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  // Bench model: one entry per rising edge after reset
  int hist  [4096];
  bit histV [4096];
  int histLen = 0;
  int lastLoad = -1;
  int coefM [TAPS];
  int seed = 7;

  always #2.5 clk = ~clk;

  systolic_fir #(.TAPS(TAPS), .XW(XW), .HW(HW)) u0 (
    .clk(clk), .rstN(rstN), .coefLoad(coefLoad), .coefIn(coefIn),
    .sampleValid(sampleValid), .sampleIn(sampleIn),
    .yValid(yValid), .yOut(yOut)
  );

  task automatic chkEq(input string tag, input longint act, input longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive on a falling edge, record the rising edge, check on the next falling edge
  task automatic cycle(input bit ld, input int c, input bit v, input int x, input string tag);
    int  k;
    bit  expV;
    longint e;
    coefLoad    = ld;
    coefIn      = HW'(c);
    sampleValid = v;
    sampleIn    = XW'(x);
    @(posedge clk);
    hist[histLen]  = (v && !ld) ? x : 0;
    histV[histLen] = v && !ld;
    if (ld) lastLoad = histLen;
    histLen++;
    @(negedge clk);
    k    = histLen - TAPS;   // slot accepted TAPS-1 edges ago
    expV = (k >= 0) ? histV[k] : 1'b0;
    chkEq({tag, " valid"}, longint'(yValid), longint'(expV));
    if (expV && k > lastLoad) begin
      e = 0;
      for (int n = 0; n < TAPS; n++)
        if (k - n >= 0) e += longint'(coefM[n]) * longint'(hist[k-n]);
      chkEq({tag, " value"}, longint'(yOut), e);
    end
  endtask

  // First value loaded is H(TAPS-1), last is H(0)
  task automatic loadCoefs(input int h[TAPS], input bit v, input int x, input string tag);
    for (int i = TAPS - 1; i >= 0; i--) cycle(1'b1, h[i], v, x, tag);
    for (int i = 0; i < TAPS; i++) coefM[i] = h[i];
  endtask

  function automatic int nextSample();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 255) - 128;
  endfunction

  task automatic testReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chkEq("R1 valid in reset", longint'(yValid), 0);
    chkEq("R1 out in reset", longint'(yOut), 0);
    rstN = 1'b1;
    for (int i = 0; i < TAPS; i++) cycle(1'b0, 0, 1'b0, 0, "R1");
    chkEq("R1 out after release", longint'(yOut), 0);
  endtask

  task automatic testImpulse();
    int h[TAPS] = '{3, -5, 7, 2, -1};
    loadCoefs(h, 1'b0, 0, "R2");
    cycle(1'b0, 0, 1'b1, 1, "R2 impulse");
    for (int i = 0; i < 2*TAPS; i++) cycle(1'b0, 0, 1'b1, 0, "R4 impulse tail");
  endtask

  task automatic testStream();
    for (int i = 0; i < 40; i++) cycle(1'b0, 0, 1'b1, nextSample(), "R3");
    // coefIn toggles while loading is off
    for (int i = 0; i < 30; i++) cycle(1'b0, nextSample(), 1'b1, nextSample(), "R8");
  endtask

  task automatic testGaps();
    for (int i = 0; i < 30; i++) cycle(1'b0, 0, (i % 3) != 1, nextSample(), "R5");
    for (int i = 0; i < 2*TAPS; i++) cycle(1'b0, 0, 1'b0, 99, "R5 idle");
    chkEq("R5 flushed out", longint'(yOut), 0);
  endtask

  task automatic testLoadPriority();
    int h[TAPS] = '{1, 2, 3, 4, 5};
    for (int i = 0; i < 4; i++) cycle(1'b0, 0, 1'b1, 10 + i, "R6 pre");
    loadCoefs(h, 1'b1, 100, "R6");
    for (int i = 0; i < 15; i++) cycle(1'b0, 0, 1'b1, nextSample(), "R6");
  endtask

  task automatic testExtreme();
    int hMin[TAPS] = '{-128, -128, -128, -128, -128};
    int hMax[TAPS] = '{127, 127, 127, 127, 127};
    loadCoefs(hMin, 1'b0, 0, "R7");
    for (int i = 0; i < 3*TAPS; i++) cycle(1'b0, 0, 1'b1, -128, "R7 min*min");
    chkEq("R7 peak", longint'(yOut), longint'(TAPS) * 16384);
    loadCoefs(hMax, 1'b0, 0, "R7");
    for (int i = 0; i < 3*TAPS; i++) cycle(1'b0, 0, 1'b1, -128, "R7 max*min");
    chkEq("R7 negative peak", longint'(yOut), -longint'(TAPS) * 16256);
  endtask

  initial begin
    for (int i = 0; i < TAPS; i++) coefM[i] = 0;
    @(negedge clk);
    testReset();
    testImpulse();
    testStream();
    testGaps();
    testLoadPriority();
    testExtreme();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(5 * 200000);
    if (!finished) begin
      finished = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule